// File: doc/BRIEF.md
# SAR Conversion Timing Engine

This block sequences one successive-approximation conversion. A start request latches the configuration: a prescaler value, a sample-time code, an 8/10-bit resolution choice and two output-format flags. The engine then derives a slow converter tick from the bus clock and holds a sample window made of two phases. After the window it runs a binary search. In each search step it drives a trial code to an external DAC and reads back one comparator bit.

When the last bit has been decided, the engine presents the raw code and a 16-bit formatted word, and pulses `done` for one cycle. The word is either right-aligned and unsigned, or left-aligned to bit 15, either unsigned or as two's complement. The comparator, DAC and input multiplexer sit outside the block. An abort input drops any conversion in progress.

Top module: `sar_conv_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `sample_en`, `dac_code`, `raw_result` and `result_word` are all zero.
- R2: One converter tick lasts 2×(P+1) bus clocks, where P is the 5-bit prescaler value (0 to 31) captured at start.
- R3: Counting from the clock edge that accepts `start`, `done` is high after exactly (2 + S + N)×2×(P+1) edges. S is 2, 4, 8 or 16 for sample code 0, 1, 2 or 3. N is 10 when `res8`=0 and 8 when `res8`=1.
- R4: `sample_en` is high for exactly (2 + S)×2×(P+1) bus cycles, starting with the cycle after the accepting edge, and is high only while `busy` is high.
- R5: `raw_result` holds the search result right-aligned, with unused upper bits zero. Each bit is kept when `cmp_in`=1 for its trial, so with a comparator that returns 1 when trial ≤ input, the result equals the input code.
- R6: The first trial code on `dac_code` is 1<<(N-1), which is mid-scale. `dac_code` is zero whenever the engine is not in the bit-search phase.
- R7: `done` is a single-cycle pulse, `busy` is low in that cycle, and `result_word` changes only in a cycle where `done` is high.
- R8: With `left_just`=0 the word is `raw_result` zero-extended from bit 0, and `signed_fmt` has no effect.
- R9: With `left_just`=1 and `signed_fmt`=0, the result MSB sits at bit 15 and the bits below the result are zero.
- R10: With `left_just`=1 and `signed_fmt`=1, the word is the left-aligned word with bit 15 inverted, which gives two's complement around mid-scale.
- R11: `abort` while `busy` returns the engine to idle at the next edge. No `done` follows, and `result_word` keeps its previous value.
- R12: `start` and configuration changes while `busy` is high do not affect the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| abort | input | 1 | Cancel the conversion in progress |
| prescale | input | 5 | Converter tick divider P |
| smp_sel | input | 2 | Second sample phase length code |
| res8 | input | 1 | 1 = 8-bit, 0 = 10-bit |
| left_just | input | 1 | 1 = align result to bit 15 |
| signed_fmt | input | 1 | 1 = two's complement (left-aligned only) |
| cmp_in | input | 1 | Comparator: 1 when trial code ≤ input |
| sample_en | output | 1 | Sample window active |
| busy | output | 1 | Conversion in progress |
| dac_code | output | RES_W (10) | Trial code for the DAC |
| done | output | 1 | One-cycle completion pulse |
| raw_result | output | RES_W (10) | Raw search result |
| result_word | output | OUT_W (16) | Formatted result |

## Verification
The bench uses the default parameters: 10-bit maximum resolution, an 8-bit reduced mode, a 16-bit word and a first sample phase of two ticks. With these values, every sample code, both resolutions and prescaler values from 0 up to 31 are short enough to run in full. The extreme prescaler of 31 makes a 768-cycle conversion. Codes at full scale, zero and mid-scale exercise the sign inversion and the zero fill in the low bits.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int PRS_W     = 5;
    localparam int SMP_W     = 2;
    localparam int PH_W      = 6;
    localparam int DIV_W     = PRS_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SAMP1 = 2'd1,
        ST_SAMP2 = 2'd2,
        ST_CONV  = 2'd3
    } sar_state_e;

    typedef struct packed {
        logic [PRS_W-1:0] prs;
        logic [SMP_W-1:0] smp;
        logic             res8;
        logic             left;
        logic             sgn;
    } sar_cfg_t;

    // length of the second sample phase in converter ticks: 2, 4, 8, 16
    function automatic logic [PH_W-1:0] phase2_ticks(input logic [SMP_W-1:0] code);
        return PH_W'(2) << code;
    endfunction

    // bus clocks per converter tick
    function automatic logic [DIV_W-1:0] tick_period(input logic [PRS_W-1:0] p);
        return (DIV_W'(p) + DIV_W'(1)) << 1;
    endfunction

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRS_W-1:0] prs,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    assign last = tick_period(prs) - DIV_W'(1);
    assign tick = run && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int LO_RES    = 8,
    parameter int PH1_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             abort,
    input  logic             tick,
    input  logic [SMP_W-1:0] smp,
    input  logic             res8,
    input  logic             cmp,
    output sar_state_e       state,
    output logic [RES_W-1:0] dac_code,
    output logic             fin,
    output logic [RES_W-1:0] res_next
);
    localparam int BIT_W = $clog2(RES_W);

    sar_state_e       st_q;
    logic [PH_W-1:0]  ph_q;
    logic [BIT_W-1:0] bit_q;
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] trial_bit;
    logic [RES_W-1:0] sar_next;
    logic [BIT_W-1:0] top_bit;

    assign top_bit   = res8 ? BIT_W'(LO_RES - 1) : BIT_W'(RES_W - 1);
    assign trial_bit = RES_W'(1) << bit_q;
    assign sar_next  = cmp ? (sar_q | trial_bit) : sar_q;
    assign fin       = (st_q == ST_CONV) && tick && (bit_q == '0) && !abort;
    assign res_next  = sar_next;
    assign dac_code  = (st_q == ST_CONV) ? (sar_q | trial_bit) : '0;
    assign state     = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ph_q  <= '0;
            bit_q <= '0;
            sar_q <= '0;
        end else if (abort && st_q != ST_IDLE) begin
            st_q  <= ST_IDLE;
            ph_q  <= '0;
            bit_q <= '0;
            sar_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (launch) begin
                        st_q  <= ST_SAMP1;
                        ph_q  <= '0;
                        sar_q <= '0;
                    end
                end
                ST_SAMP1: begin
                    if (tick) begin
                        if (ph_q == PH_W'(PH1_TICKS - 1)) begin
                            st_q <= ST_SAMP2;
                            ph_q <= '0;
                        end else begin
                            ph_q <= ph_q + PH_W'(1);
                        end
                    end
                end
                ST_SAMP2: begin
                    if (tick) begin
                        if (ph_q == phase2_ticks(smp) - PH_W'(1)) begin
                            st_q  <= ST_CONV;
                            ph_q  <= '0;
                            bit_q <= top_bit;
                        end else begin
                            ph_q <= ph_q + PH_W'(1);
                        end
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        if (bit_q == '0) begin
                            st_q  <= ST_IDLE;
                            sar_q <= '0;
                        end else begin
                            sar_q <= sar_next;
                            bit_q <= bit_q - BIT_W'(1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_fmt.sv
module sar_fmt #(
    parameter int RES_W  = 10,
    parameter int LO_RES = 8,
    parameter int OUT_W  = 16
) (
    input  logic [RES_W-1:0] raw,
    input  logic             res8,
    input  logic             left,
    input  logic             sgn,
    output logic [OUT_W-1:0] word
);
    localparam int SH_HI = OUT_W - RES_W;
    localparam int SH_LO = OUT_W - LO_RES;

    always_comb begin
        word = OUT_W'(raw);
        if (left) begin
            word = res8 ? (OUT_W'(raw) << SH_LO) : (OUT_W'(raw) << SH_HI);
            if (sgn) begin
                word[OUT_W-1] = ~word[OUT_W-1];
            end
        end
    end
endmodule

// File: rtl/sar_conv_engine.sv
module sar_conv_engine
    import sar_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int LO_RES    = 8,
    parameter int OUT_W     = 16,
    parameter int PH1_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [4:0]       prescale,
    input  logic [1:0]       smp_sel,
    input  logic             res8,
    input  logic             left_just,
    input  logic             signed_fmt,
    input  logic             cmp_in,
    output logic             sample_en,
    output logic             busy,
    output logic [RES_W-1:0] dac_code,
    output logic             done,
    output logic [RES_W-1:0] raw_result,
    output logic [OUT_W-1:0] result_word
);
    sar_cfg_t         cfg_q;
    sar_state_e       state;
    logic             launch;
    logic             tick;
    logic             fin;
    logic [RES_W-1:0] res_next;
    logic [OUT_W-1:0] word_next;
    logic             done_q;
    logic [RES_W-1:0] raw_q;
    logic [OUT_W-1:0] word_q;
    logic             cfg_left;

    assign launch   = start && !abort && (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign sample_en = (state == ST_SAMP1) || (state == ST_SAMP2);
    assign cfg_left = cfg_q.left;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (launch) begin
            cfg_q <= '{prs: prescale, smp: smp_sel, res8: res8,
                       left: left_just, sgn: signed_fmt};
        end
    end

    sar_tick_gen u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .prs  (cfg_q.prs),
        .tick (tick)
    );

    sar_seq #(
        .RES_W     (RES_W),
        .LO_RES    (LO_RES),
        .PH1_TICKS (PH1_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .abort    (abort),
        .tick     (tick),
        .smp      (cfg_q.smp),
        .res8     (cfg_q.res8),
        .cmp      (cmp_in),
        .state    (state),
        .dac_code (dac_code),
        .fin      (fin),
        .res_next (res_next)
    );

    sar_fmt #(
        .RES_W  (RES_W),
        .LO_RES (LO_RES),
        .OUT_W  (OUT_W)
    ) u_fmt (
        .raw  (res_next),
        .res8 (cfg_q.res8),
        .left (cfg_q.left),
        .sgn  (cfg_q.sgn),
        .word (word_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            raw_q  <= '0;
            word_q <= '0;
        end else begin
            done_q <= fin;
            if (fin) begin
                raw_q  <= res_next;
                word_q <= word_next;
            end
        end
    end

    assign done        = done_q;
    assign raw_result  = raw_q;
    assign result_word = word_q;
endmodule

// File: rtl/sar_conv_engine_chk.sv
module sar_conv_engine_chk #(
    parameter int RES_W = 10,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             abort,
    input logic             busy,
    input logic             sample_en,
    input logic             done,
    input logic [RES_W-1:0] dac_code,
    input logic [OUT_W-1:0] result_word,
    input logic             cfg_left
);
    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: engine is idle when completion is flagged
    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: completion only follows a busy cycle
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R7: output word moves only together with done
    a_r7_word_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_word) |-> done);

    // R11: abort drops busy with no completion
    a_r11_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (busy && abort) |=> (!busy && !done));

    // R4: sample window lies inside busy
    a_r4_sample_in_busy: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> busy);

    // R12: while sampling, without abort, the conversion keeps running
    a_r12_keep_running: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !abort) |=> busy);

    // R6: trial code is zero outside a conversion and during sampling
    a_r6_dac_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy || sample_en) |-> (dac_code == '0));

    // R8: right-aligned word has clear upper bits
    a_r8_right_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg_left) |-> (result_word[OUT_W-1:RES_W] == '0));
endmodule

bind sar_conv_engine sar_conv_engine_chk #(
    .RES_W (RES_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .abort       (abort),
    .busy        (busy),
    .sample_en   (sample_en),
    .done        (done),
    .dac_code    (dac_code),
    .result_word (result_word),
    .cfg_left    (cfg_left)
);

// File: tb/sar_conv_engine_tb.sv
module sar_conv_engine_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        abort;
    logic [4:0]  prescale;
    logic [1:0]  smp_sel;
    logic        res8;
    logic        left_just;
    logic        signed_fmt;
    logic        cmp_in;
    logic        sample_en;
    logic        busy;
    logic [9:0]  dac_code;
    logic        done;
    logic [9:0]  raw_result;
    logic [15:0] result_word;
    logic [9:0]  target;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // comparator model: 1 when trial <= input
    assign cmp_in = (dac_code <= target);

    sar_conv_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .prescale(prescale), .smp_sel(smp_sel), .res8(res8),
        .left_just(left_just), .signed_fmt(signed_fmt), .cmp_in(cmp_in),
        .sample_en(sample_en), .busy(busy), .dac_code(dac_code),
        .done(done), .raw_result(raw_result), .result_word(result_word)
    );

    typedef struct packed {
        logic [4:0] prs;
        logic [1:0] smp;
        logic       r8;
        logic       lj;
        logic       sg;
        logic [9:0] tgt;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{5'd0,  2'd0, 1'b1, 1'b0, 1'b0, 10'h0A5},
        '{5'd0,  2'd3, 1'b0, 1'b0, 1'b0, 10'h3FF},
        '{5'd1,  2'd1, 1'b0, 1'b1, 1'b0, 10'h201},
        '{5'd2,  2'd2, 1'b1, 1'b1, 1'b1, 10'h000},
        '{5'd0,  2'd0, 1'b0, 1'b1, 1'b1, 10'h155},
        '{5'd3,  2'd3, 1'b0, 1'b0, 1'b1, 10'h000},
        '{5'd31, 2'd0, 1'b1, 1'b1, 1'b0, 10'h080},
        '{5'd0,  2'd2, 1'b0, 1'b1, 1'b1, 10'h3FF}
    };

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_cycles(input vec_t v);
        int nbits = v.r8 ? 8 : 10;
        return (2 + (2 << v.smp) + nbits) * 2 * (int'(v.prs) + 1);
    endfunction

    function automatic logic [15:0] exp_word(input vec_t v);
        logic [15:0] w;
        if (!v.lj) return {6'b0, v.tgt};
        w = v.r8 ? {v.tgt[7:0], 8'b0} : {v.tgt, 6'b0};
        if (v.sg) w[15] = ~w[15];
        return w;
    endfunction

    task automatic apply_cfg(input vec_t v);
        prescale = v.prs; smp_sel = v.smp; res8 = v.r8;
        left_just = v.lj; signed_fmt = v.sg; target = v.tgt;
    endtask

    // run one conversion; optionally re-pulse start mid-way with alt config
    task automatic run_conv(input vec_t v, input logic poke, input vec_t alt);
        int cyc = 0;
        int smp_cyc = 0;
        int first = -1;
        logic seen = 1'b0;
        @(negedge clk);
        apply_cfg(v);
        start = 1'b1;
        @(posedge clk);
        #1;
        if (sample_en) smp_cyc++;
        @(negedge clk);
        start = 1'b0;
        while (!seen && cyc < 5000) begin
            if (poke && cyc == 10) begin
                prescale = alt.prs; smp_sel = alt.smp; res8 = alt.r8;
                left_just = alt.lj; signed_fmt = alt.sg; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            #1;
            cyc++;
            if (sample_en) smp_cyc++;
            if (busy && !sample_en && first < 0) first = int'(dac_code);
            if (done) seen = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        check(seen && cyc == exp_cycles(v), "R3 conversion length (R2 tick)",
              cyc, exp_cycles(v));
        check(smp_cyc == (2 + (2 << v.smp)) * 2 * (int'(v.prs) + 1),
              "R4 sample window", smp_cyc, (2 + (2 << v.smp)) * 2 * (int'(v.prs) + 1));
        check(first == (v.r8 ? 32'h80 : 32'h200), "R6 first trial",
              first, v.r8 ? 32'h80 : 32'h200);
        check(raw_result == v.tgt, "R5 raw result", raw_result, v.tgt);
        check(result_word == exp_word(v), "R8/R9/R10 word", result_word, exp_word(v));
        check(!busy, "R7 idle at done", busy, 0);
        @(posedge clk);
        #1;
        check(!done, "R7 single pulse", done, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t none;
        vec_t base;
        vec_t alt;
        logic [15:0] held;
        int stray;
        none = '0;
        rst = 1'b1; start = 1'b0; abort = 1'b0;
        apply_cfg(none);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(!busy && !done && !sample_en, "R1 control outputs",
              {busy, done, sample_en}, 0);
        check(dac_code == 0 && raw_result == 0 && result_word == 0,
              "R1 data outputs", result_word, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            run_conv(VECS[i], 1'b0, none);
        end

        // R12: start and new config while busy are ignored
        base = '{5'd1, 2'd0, 1'b1, 1'b0, 1'b0, 10'h03C};
        alt  = '{5'd0, 2'd3, 1'b0, 1'b1, 1'b1, 10'h03C};
        run_conv(base, 1'b1, alt);

        // R11: abort mid-conversion
        held = result_word;
        @(negedge clk);
        apply_cfg('{5'd0, 2'd0, 1'b0, 1'b1, 1'b0, 10'h2AA});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (14) @(negedge clk);
        check(busy && !sample_en, "R11 in search before abort", busy, 1);
        abort = 1'b1;
        @(posedge clk);
        #1;
        check(!busy, "R11 idle after abort", busy, 0);
        check(dac_code == 0, "R11 trial cleared", dac_code, 0);
        @(negedge clk);
        abort = 1'b0;
        stray = 0;
        repeat (100) begin
            @(posedge clk);
            #1;
            if (done || busy) stray++;
        end
        check(stray == 0, "R11 no done after abort", stray, 0);
        check(result_word == held, "R11 word kept", result_word, held);

        // engine still usable after abort
        run_conv('{5'd0, 2'd1, 1'b0, 1'b1, 1'b1, 10'h1FF}, 1'b0, none);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule